// File: doc/BRIEF.md
# Arithmetic Flag and Condition Code Unit

This block holds the eight-bit condition code register of a small 8-bit datapath and computes the arithmetic results that update it. For each valid operation it forms a sum, a difference or a decimal-corrected value of the accumulator operand, registers that value, and sets the carry, overflow, zero, negative and (for additions) half-carry flags to match. The half-carry flag keeps the carry out of the low nibble of the last addition. A later decimal-adjust operation reads it together with carry to turn a binary sum of two packed-BCD bytes into a valid packed-BCD byte.

Three control bits share the register with the arithmetic flags. They are a stop disable, a mask for the non-maskable request and a mask for maskable interrupts. A synchronous reset sets these three and leaves the five arithmetic flags untouched. Software can rewrite the whole register through a write port. The non-maskable mask is the only exception: once cleared, it can be set again only by reset. The unit drives a stop-allowed level, a maskable interrupt enable and a gated copy of the non-maskable request, all decoded from the register.

Top module: `ccr_flag_unit`

## Requirements
- R1: The register bits from bit 7 down to bit 0 are stop disable, non-maskable mask, half-carry, interrupt mask, negative, zero, overflow, carry. A cycle with `rst` high sets bits 7, 6 and 4 to 1 and keeps bits 5, 3, 2, 1 and 0 unchanged. Any operation or write in that cycle is discarded.
- R2: Op code 0 (add) and op code 5 (add B into A) register `opnd_a + opnd_b` modulo 256. They set carry to the carry out of bit 7 and half-carry to the carry out of bit 3.
- R3: Op code 1 (add with carry) registers `opnd_a + opnd_b + C`. Carry and half-carry follow the same rule as R2, with C included.
- R4: Op code 2 (subtract) registers `opnd_a - opnd_b` and op code 3 (subtract with borrow) registers `opnd_a - opnd_b - C`. Carry is set exactly when the unsigned subtrahend plus borrow-in exceeds `opnd_a`. Half-carry is not changed.
- R5: Overflow is set when an add gives a result whose sign differs from two operands of equal sign, or when a subtract of operands with different signs gives a result whose sign differs from `opnd_a`. Otherwise overflow is cleared.
- R6: After every valid operation, negative equals bit 7 of the registered result and zero is set exactly when the registered result is 0.
- R7: Op code 4 (decimal adjust) works on `opnd_a`. It adds 0x06 when the low nibble is above 9 or half-carry is 1. It adds 0x60 when carry is 1, when the high nibble is above 9, or when the high nibble is 9 and the low nibble is above 9. Carry becomes carry OR (0x60 applied). Half-carry and overflow are unchanged.
- R8: When `op_valid` is low, or when the op code is 6 or 7, the result and the register keep their values.
- R9: With `wr_en` high, the register takes `wr_data`, except that bit 6 becomes old bit 6 AND `wr_data[6]`. A write in the same cycle as a valid operation decides the whole register, and the operation still updates the result.
- R10: `stop_ok` is low exactly when bit 7 is 1. `irq_en` is low exactly when bit 4 is 1. `nmi_pass` equals `nmi_req` while bit 6 is 0 and is low while bit 6 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of the control bits, active high |
| op_valid | input | 1 | Operation strobe for this cycle |
| op_code | input | 3 | Operation selector (0..5 used, 6..7 reserved) |
| opnd_a | input | DW | Accumulator operand |
| opnd_b | input | DW | Second operand |
| wr_en | input | 1 | Direct register write strobe |
| wr_data | input | 8 | Value for a direct register write |
| nmi_req | input | 1 | Non-maskable request before masking |
| result | output | DW | Registered result of the last valid operation |
| ccr | output | 8 | Current register value |
| stop_ok | output | 1 | High when the stop operation is permitted |
| irq_en | output | 1 | High when maskable interrupts are enabled |
| nmi_pass | output | 1 | Non-maskable request after the mask |

## Verification
The bench builds the unit with the default `DW` of 8. Packed-BCD correction only has a meaning at that width. At this width the bench can run decimal adjust on every one of the 256 accumulator values under all four half-carry/carry combinations, so it hits every correction boundary, including the high nibble of 9 with a low nibble above 9. The same width lets the add and subtract sweeps reach the nibble carry, the byte carry and both signed overflow corners.

// File: rtl/ccr_pkg.sv
`timescale 1ns/1ps
package ccr_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_DAA = 3'd4,
        OP_ABA = 3'd5
    } alu_op_e;

    localparam logic [2:0] OP_LAST = 3'd5;

    // field order follows the register bit order, bit 7 first
    typedef struct packed {
        logic stp;
        logic xmsk;
        logic half;
        logic imsk;
        logic neg;
        logic zero;
        logic ovf;
        logic cry;
    } ccr_t;

    localparam int CCR_W   = 8;
    localparam int BIT_XM  = 6;

endpackage

// File: rtl/ccr_addsub.sv
`timescale 1ns/1ps
module ccr_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  logic          sub_i,
    output logic [DW-1:0] sum_o,
    output logic          cry_o,
    output logic          half_o,
    output logic          ovf_o
);
    localparam int NIB = DW / 2;

    logic [DW:0]  full;
    logic [NIB:0] low;
    logic         sa, sb, sr;

    always_comb begin
        if (sub_i) begin
            full = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, cin_i};
            low  = {1'b0, a_i[NIB-1:0]} - {1'b0, b_i[NIB-1:0]} - {{NIB{1'b0}}, cin_i};
        end else begin
            full = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
            low  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
        end
        sum_o  = full[DW-1:0];
        cry_o  = full[DW];
        half_o = low[NIB];
        sa = a_i[DW-1];
        sb = b_i[DW-1];
        sr = full[DW-1];
        if (sub_i) begin
            ovf_o = (sa != sb) && (sr != sa);
        end else begin
            ovf_o = (sa == sb) && (sr != sa);
        end
    end
endmodule

// File: rtl/ccr_decadj.sv
`timescale 1ns/1ps
module ccr_decadj #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic          half_i,
    input  logic          cry_i,
    output logic [DW-1:0] res_o,
    output logic          cry_o
);
    localparam int NIB = DW / 2;
    localparam logic [NIB-1:0] NINE = NIB'(9);
    localparam logic [NIB-1:0] SIX  = NIB'(6);

    logic [NIB-1:0] lo, hi;
    logic           lo_big, hi_big, fix_lo, fix_hi;
    logic [DW-1:0]  corr;

    always_comb begin
        lo     = a_i[NIB-1:0];
        hi     = a_i[DW-1:NIB];
        lo_big = lo > NINE;
        hi_big = hi > NINE;
        fix_lo = lo_big || half_i;
        fix_hi = cry_i || hi_big || ((hi == NINE) && lo_big);
        corr   = {(fix_hi ? SIX : {NIB{1'b0}}), (fix_lo ? SIX : {NIB{1'b0}})};
        res_o  = a_i + corr;
        cry_o  = cry_i || fix_hi;
    end
endmodule

// File: rtl/ccr_flag_unit.sv
`timescale 1ns/1ps
module ccr_flag_unit #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [2:0]    op_code,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          nmi_req,
    output logic [DW-1:0] result,
    output logic [7:0]    ccr,
    output logic          stop_ok,
    output logic          irq_en,
    output logic          nmi_pass
);
    import ccr_pkg::*;

    typedef struct packed {
        ccr_t          flags;
        logic [DW-1:0] res;
    } unit_st_t;

    unit_st_t st_d, st_q;

    // arithmetic operand steering
    logic          is_sub, use_cin, legal;
    logic [DW-1:0] as_sum, da_res;
    logic          as_cry, as_half, as_ovf, da_cry;
    alu_op_e       op;

    always_comb begin
        op      = alu_op_e'(op_code);
        legal   = op_code <= OP_LAST;
        is_sub  = (op == OP_SUB) || (op == OP_SBC);
        use_cin = ((op == OP_ADC) || (op == OP_SBC)) && st_q.flags.cry;
    end

    ccr_addsub #(.DW(DW)) i_addsub (
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .cin_i  (use_cin),
        .sub_i  (is_sub),
        .sum_o  (as_sum),
        .cry_o  (as_cry),
        .half_o (as_half),
        .ovf_o  (as_ovf)
    );

    ccr_decadj #(.DW(DW)) i_decadj (
        .a_i    (opnd_a),
        .half_i (st_q.flags.half),
        .cry_i  (st_q.flags.cry),
        .res_o  (da_res),
        .cry_o  (da_cry)
    );

    always_comb begin
        st_d = st_q;
        if (op_valid && legal) begin
            case (op)
                OP_ADD, OP_ADC, OP_ABA: begin
                    st_d.res        = as_sum;
                    st_d.flags.cry  = as_cry;
                    st_d.flags.half = as_half;
                    st_d.flags.ovf  = as_ovf;
                end
                OP_SUB, OP_SBC: begin
                    st_d.res        = as_sum;
                    st_d.flags.cry  = as_cry;
                    st_d.flags.ovf  = as_ovf;
                end
                default: begin
                    st_d.res        = da_res;
                    st_d.flags.cry  = da_cry;
                end
            endcase
            st_d.flags.neg  = st_d.res[DW-1];
            st_d.flags.zero = (st_d.res == '0);
        end
        if (wr_en) begin
            st_d.flags      = ccr_t'(wr_data);
            st_d.flags.xmsk = st_q.flags.xmsk & wr_data[BIT_XM];
        end
        if (rst) begin
            st_d            = st_q;
            st_d.flags.stp  = 1'b1;
            st_d.flags.xmsk = 1'b1;
            st_d.flags.imsk = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        result   = st_q.res;
        ccr      = st_q.flags;
        stop_ok  = !st_q.flags.stp;
        irq_en   = !st_q.flags.imsk;
        nmi_pass = nmi_req && !st_q.flags.xmsk;
    end
endmodule

// File: rtl/ccr_flag_unit_chk.sv
`timescale 1ns/1ps
module ccr_flag_unit_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          op_valid,
    input logic [2:0]    op_code,
    input logic          wr_en,
    input logic [DW-1:0] result,
    input logic [7:0]    ccr
);
    logic upd;
    logic no_half;
    assign upd     = op_valid && !wr_en && !rst && (op_code <= 3'd5);
    assign no_half = (op_code == 3'd2) || (op_code == 3'd3) || (op_code == 3'd4);

    // R1: control bits set once reset is released
    a_r1_reset_sets_ctrl: assert property (@(posedge clk)
        $fell(rst) |-> (ccr[7] && ccr[6] && ccr[4]));

    // R9: non-maskable mask cannot rise outside reset
    a_r9_xmask_sticky: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> !$rose(ccr[6]));

    // R8: quiet cycles leave the register alone
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !wr_en && (!op_valid || op_code > 3'd5)) |-> ($stable(ccr) && $stable(result)));

    // R6: zero flag agrees with the registered result
    a_r6_zero_match: assert property (@(posedge clk) disable iff (rst)
        $past(upd) |-> (ccr[2] == (result == '0)));

    // R6: negative flag agrees with the result sign
    a_r6_neg_match: assert property (@(posedge clk) disable iff (rst)
        $past(upd) |-> (ccr[3] == result[DW-1]));

    // R4 / R7: half-carry untouched by subtracts and decimal adjust
    a_r4_half_kept: assert property (@(posedge clk) disable iff (rst)
        $past(upd && no_half) |-> (ccr[5] == $past(ccr[5])));

    // R7: decimal adjust never clears carry
    a_r7_carry_kept: assert property (@(posedge clk) disable iff (rst)
        $past(upd && op_code == 3'd4 && ccr[0]) |-> ccr[0]);
endmodule

bind ccr_flag_unit ccr_flag_unit_chk #(.DW(DW)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_code  (op_code),
    .wr_en    (wr_en),
    .result   (result),
    .ccr      (ccr)
);

// File: tb/test_ccr_flag_unit.sv
`timescale 1ns/1ps
module test_ccr_flag_unit;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          op_valid = 1'b0;
    logic [2:0]    op_code = 3'd0;
    logic [DW-1:0] opnd_a = '0;
    logic [DW-1:0] opnd_b = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = 8'h00;
    logic          nmi_req = 1'b0;
    logic [DW-1:0] result;
    logic [7:0]    ccr;
    logic          stop_ok, irq_en, nmi_pass;

    int   n_vec = 0;
    int   n_bad = 0;
    logic done = 1'b0;
    logic [7:0] m_ccr;
    logic [7:0] m_res;

    always #2.5 clk = ~clk;

    ccr_flag_unit #(.DW(DW)) i_ccr_flag_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .wr_en(wr_en), .wr_data(wr_data),
        .nmi_req(nmi_req), .result(result), .ccr(ccr), .stop_ok(stop_ok),
        .irq_en(irq_en), .nmi_pass(nmi_pass)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // model of one operation from the requirements: returns {flags, result}
    function automatic logic [15:0] model(input logic [2:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [7:0] f);
        logic [7:0] n, r;
        int ci, s, lo, hi;
        logic fl, fh;
        n = f;
        ci = f[0] ? 1 : 0;
        r = 8'h00;
        case (op)
            3'd0, 3'd1, 3'd5: begin
                if (op != 3'd1) ci = 0;
                s = int'(a) + int'(b) + ci;
                r = 8'(s);
                n[0] = s > 255;
                n[5] = (int'(a & 8'h0f) + int'(b & 8'h0f) + ci) > 15;
                n[1] = (a[7] == b[7]) && (r[7] != a[7]);
            end
            3'd2, 3'd3: begin
                if (op != 3'd3) ci = 0;
                s = int'(a) - int'(b) - ci;
                r = 8'(s);
                n[0] = (int'(b) + ci) > int'(a);
                n[1] = (a[7] != b[7]) && (r[7] != a[7]);
            end
            default: begin
                lo = int'(a & 8'h0f);
                hi = int'(a >> 4);
                fl = (lo > 9) || f[5];
                fh = f[0] || (hi > 9) || ((hi == 9) && (lo > 9));
                r = 8'(int'(a) + (fh ? 96 : 0) + (fl ? 6 : 0));
                n[0] = f[0] | fh;
            end
        endcase
        n[3] = r[7];
        n[2] = (r == 8'h00);
        return {n, r};
    endfunction

    task automatic do_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
        op_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic do_wr(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_model(input string tag, input logic [2:0] op,
                             input logic [7:0] a, input logic [7:0] b);
        logic [15:0] m;
        m = model(op, a, b, m_ccr);
        do_op(op, a, b);
        m_ccr = m[15:8];
        m_res = m[7:0];
        chk({tag, " result"}, int'(result), int'(m_res));
        chk({tag, " flags"}, int'(ccr), int'(m_ccr));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 control bits after reset", int'(ccr & 8'hd0), 'hd0);
        do_wr(8'h25);
        chk("R1 preload", int'(ccr), 'h25);
        rst = 1'b1;
        op_valid = 1'b1; op_code = 3'd0; opnd_a = 8'hff; opnd_b = 8'h01;
        @(negedge clk);
        rst = 1'b0; op_valid = 1'b0;
        chk("R1 arithmetic flags kept over reset", int'(ccr), 'hf5);
        do_wr(8'h00);
        m_ccr = 8'h00;
        chk("R1 register cleared by write", int'(ccr), 'h00);
    endtask

    task automatic t_add();
        for (int i = 0; i < 256; i++) begin
            logic [7:0] a, b;
            a = 8'(i * 37 + 5);
            b = 8'(i * 11 + (i >> 3));
            run_model("R2 R5 R6 add", (i % 2 == 0) ? 3'd0 : 3'd5, a, b);
        end
        do_wr(8'h00); m_ccr = 8'h00;
        run_model("R2 nibble carry", 3'd0, 8'h0f, 8'h01);
        run_model("R5 positive overflow", 3'd0, 8'h7f, 8'h01);
        run_model("R5 negative overflow", 3'd5, 8'h80, 8'h80);
        run_model("R6 zero from add", 3'd0, 8'hff, 8'h01);
    endtask

    task automatic t_adc();
        for (int i = 0; i < 64; i++) begin
            do_wr(8'(i & 1)); m_ccr = 8'(i & 1);
            run_model("R3 add with carry", 3'd1, 8'(i * 29), 8'(255 - i * 7));
        end
        do_wr(8'h01); m_ccr = 8'h01;
        run_model("R3 carry into bit 4", 3'd1, 8'h0f, 8'h00);
    endtask

    task automatic t_sub();
        for (int i = 0; i < 128; i++) begin
            logic [7:0] pre;
            pre = 8'(i * 13) & 8'hbf;
            do_wr(pre); m_ccr = pre;
            run_model("R4 R5 subtract", (i % 2 == 0) ? 3'd2 : 3'd3, 8'(i * 53 + 1), 8'(i * 19));
        end
        do_wr(8'h21); m_ccr = 8'h21;
        run_model("R4 borrow equal operands", 3'd3, 8'h40, 8'h40);
        run_model("R5 subtract overflow", 3'd2, 8'h80, 8'h01);
    endtask

    task automatic t_daa();
        for (int hc = 0; hc < 4; hc++) begin
            for (int a = 0; a < 256; a++) begin
                logic [7:0] pre;
                pre = ((hc & 2) != 0 ? 8'h20 : 8'h00) | ((hc & 1) != 0 ? 8'h03 : 8'h00);
                do_wr(pre); m_ccr = pre;
                run_model("R7 decimal adjust", 3'd4, 8'(a), 8'h5a);
            end
        end
    endtask

    task automatic t_idle();
        logic [7:0] keep_c, keep_r;
        do_wr(8'h2b);
        do_op(3'd0, 8'h12, 8'h34);
        keep_c = ccr; keep_r = result;
        op_code = 3'd2; opnd_a = 8'h99; opnd_b = 8'h01;
        repeat (3) @(negedge clk);
        chk("R8 idle flags", int'(ccr), int'(keep_c));
        chk("R8 idle result", int'(result), int'(keep_r));
        do_op(3'd6, 8'hff, 8'hff);
        chk("R8 reserved 6 flags", int'(ccr), int'(keep_c));
        do_op(3'd7, 8'h00, 8'h00);
        chk("R8 reserved 7 result", int'(result), int'(keep_r));
    endtask

    task automatic t_write();
        do_wr(8'h40);
        chk("R9 mask cannot be set", int'(ccr), 'h00);
        do_wr(8'h9a);
        chk("R9 write plain bits", int'(ccr), 'h9a);
        do_wr(8'hff);
        chk("R9 all ones without mask", int'(ccr), 'hbf);
        wr_en = 1'b1; wr_data = 8'h10;
        do_op(3'd0, 8'h70, 8'h10);
        wr_en = 1'b0;
        chk("R9 write beats op flags", int'(ccr), 'h10);
        chk("R9 op result still taken", int'(result), 'h80);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        do_wr(8'h00);
        chk("R9 mask cleared by write", int'(ccr), 'h00);
    endtask

    task automatic t_pins();
        do_wr(8'h00);
        nmi_req = 1'b1;
        #1;
        chk("R10 stop allowed", int'(stop_ok), 1);
        chk("R10 irq enabled", int'(irq_en), 1);
        chk("R10 nmi passes", int'(nmi_pass), 1);
        do_wr(8'h90);
        chk("R10 stop blocked", int'(stop_ok), 0);
        chk("R10 irq masked", int'(irq_en), 0);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R10 nmi masked", int'(nmi_pass), 0);
        nmi_req = 1'b0;
        do_wr(8'h00);
        chk("R10 nmi idle", int'(nmi_pass), 0);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        m_ccr = 8'h00;
        m_res = 8'h00;
        @(negedge clk);
        t_reset();
        t_add();
        t_adc();
        t_sub();
        t_daa();
        t_idle();
        t_write();
        t_pins();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
            $finish;
        end
    end
endmodule